// File: doc/BRIEF.md
# Packet Payload Trailer Appender

This block sits between a payload receiver and a transmit FIFO. While idle it passes every valid payload byte straight to the FIFO write port in the same cycle. When the receiver signals the end of a packet, the block takes over the write port for eighteen consecutive cycles. In those cycles it writes a fixed trailer: a line feed followed by the ASCII text `nihaoya,dongwazi~`.

It records the transmit length as the received byte count plus eighteen. After the last trailer byte it raises a one-cycle start strobe for the transmit side. The destination MAC and IP addresses pass through unchanged.

Typical use: a 5-byte payload `HELLO` yields the FIFO stream `HELLO` plus the trailer (23 bytes), a length of 23, and one start strobe.

Top module: `pkt_trailer_append`

## Requirements
- R1: While no trailer is being written, each cycle with `byte_vld` high asserts `fifo_we` in that same cycle, with `fifo_wdata` equal to `byte_in`.
- R2: Starting in the cycle after `pkt_end` is sampled high while idle, exactly 18 bytes are written on 18 consecutive cycles. In order they are 0x0A, then the ASCII codes of `nihaoya,dongwazi~` (0x6E first, 0x7E last).
- R3: `tx_len` takes the value `rx_len` + 18 (modulo 2^LEN_W) at the clock edge where `pkt_end` is accepted. It holds that value until the next accepted `pkt_end`.
- R4: `tx_go` is high for exactly one cycle per packet, in the cycle right after the write of the last trailer byte.
- R5: `pkt_end` and `byte_vld` are ignored during the 18 trailer cycles. They add no FIFO write, do not change the trailer bytes, do not change `tx_len` and do not add a `tx_go` strobe.
- R6: `fifo_we` is high only in a cycle with `byte_vld` high while idle, or in a trailer cycle.
- R7: `dst_mac_o` always equals `dst_mac_i` and `dst_ip_o` always equals `dst_ip_i`.
- R8: While `rst_n` is low, `fifo_we` and `tx_go` are 0 and `tx_len` is 0.
- R9: If `byte_vld` and `pkt_end` are high in the same idle cycle, that byte is written, and the trailer follows from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_vld | input | 1 | Payload byte valid |
| byte_in | input | 8 | Payload byte |
| pkt_end | input | 1 | End-of-packet strobe |
| rx_len | input | LEN_W | Received payload length in bytes |
| dst_mac_i | input | MAC_W | Destination MAC address in |
| dst_ip_i | input | IP_W | Destination IP address in |
| fifo_we | output | 1 | FIFO write enable |
| fifo_wdata | output | 8 | FIFO write data |
| tx_len | output | LEN_W | Transmit length (payload plus trailer) |
| tx_go | output | 1 | One-cycle transmit start strobe |
| dst_mac_o | output | MAC_W | Destination MAC address out |
| dst_ip_o | output | IP_W | Destination IP address out |

## Verification
Payload lengths are swept from zero to two dozen bytes, each with a length-dependent data pattern, with the end strobe arriving one cycle after the last byte. This checks byte ordering, trailer placement, length arithmetic and strobe timing over every short length, including an empty payload. A second pattern raises the end strobe together with the last byte, which shows whether that byte is kept and the trailer starts on time. A third pattern injects stray valid bytes and a second end strobe with a different length during the trailer, which separates a design that ignores them from one that restarts, extends or overwrites. A near-maximum received length checks that the length sum wraps.

// File: rtl/pkt_trailer_append.sv
module pkt_trailer_append #(
  parameter int LEN_W = 16,
  parameter int MAC_W = 48,
  parameter int IP_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  input  logic             pkt_end,
  input  logic [LEN_W-1:0] rx_len,
  input  logic [MAC_W-1:0] dst_mac_i,
  input  logic [IP_W-1:0]  dst_ip_i,
  output logic             fifo_we,
  output logic [7:0]       fifo_wdata,
  output logic [LEN_W-1:0] tx_len,
  output logic             tx_go,
  output logic [MAC_W-1:0] dst_mac_o,
  output logic [IP_W-1:0]  dst_ip_o
);
  localparam int              TRL_N    = 18;
  localparam int              IDX_W    = 6;
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(TRL_N - 1);
  localparam logic [LEN_W-1:0] TRL_ADD = LEN_W'(TRL_N);

  logic             busy;
  logic [IDX_W-1:0] idx;

  function automatic logic [7:0] trl_byte(input logic [IDX_W-1:0] i);
    case (i)
      6'd0:    trl_byte = 8'h0A;
      6'd1:    trl_byte = 8'h6E;
      6'd2:    trl_byte = 8'h69;
      6'd3:    trl_byte = 8'h68;
      6'd4:    trl_byte = 8'h61;
      6'd5:    trl_byte = 8'h6F;
      6'd6:    trl_byte = 8'h79;
      6'd7:    trl_byte = 8'h61;
      6'd8:    trl_byte = 8'h2C;
      6'd9:    trl_byte = 8'h64;
      6'd10:   trl_byte = 8'h6F;
      6'd11:   trl_byte = 8'h6E;
      6'd12:   trl_byte = 8'h67;
      6'd13:   trl_byte = 8'h77;
      6'd14:   trl_byte = 8'h61;
      6'd15:   trl_byte = 8'h7A;
      6'd16:   trl_byte = 8'h69;
      6'd17:   trl_byte = 8'h7E;
      default: trl_byte = 8'h00;
    endcase
  endfunction

  wire accept_end = pkt_end && !busy;

  assign fifo_we    = busy || byte_vld;
  assign fifo_wdata = busy ? trl_byte(idx) : byte_in;
  assign dst_mac_o  = dst_mac_i;
  assign dst_ip_o   = dst_ip_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      tx_len <= '0;
      tx_go  <= 1'b0;
    end else begin
      tx_go <= 1'b0;
      if (accept_end) begin
        busy   <= 1'b1;
        idx    <= '0;
        tx_len <= rx_len + TRL_ADD;
      end else if (busy) begin
        if (idx == IDX_END) begin
          busy  <= 1'b0;
          idx   <= '0;
          tx_go <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pkt_trailer_append_chk.sv
module pkt_trailer_append_chk #(
  parameter int LEN_W = 16,
  parameter int MAC_W = 48,
  parameter int IP_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic             pkt_end,
  input logic             fifo_we,
  input logic [7:0]       fifo_wdata,
  input logic [LEN_W-1:0] tx_len,
  input logic             tx_go,
  input logic             busy,
  input logic [5:0]       idx,
  input logic [MAC_W-1:0] dst_mac_i,
  input logic [MAC_W-1:0] dst_mac_o,
  input logic [IP_W-1:0]  dst_ip_i,
  input logic [IP_W-1:0]  dst_ip_o
);
  p_go_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |=> !tx_go);

  p_go_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_go) |-> $past(fifo_we && busy && fifo_wdata == 8'h7E));

  p_len_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pkt_end && !busy) |-> $stable(tx_len));

  p_trl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> fifo_we);

  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> idx == $past(idx) + 6'd1);

  p_idle_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_we && !busy) |-> byte_vld);

  p_ignore_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pkt_end && idx != 6'd17) |=> busy);

  p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dst_mac_o == dst_mac_i && dst_ip_o == dst_ip_i);
endmodule

bind pkt_trailer_append pkt_trailer_append_chk #(
  .LEN_W(LEN_W), .MAC_W(MAC_W), .IP_W(IP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .pkt_end(pkt_end),
  .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .tx_len(tx_len), .tx_go(tx_go),
  .busy(busy), .idx(idx), .dst_mac_i(dst_mac_i), .dst_mac_o(dst_mac_o),
  .dst_ip_i(dst_ip_i), .dst_ip_o(dst_ip_o)
);

// File: tb/tb_pkt_trailer_append.sv
`timescale 1ns/1ps
module tb_pkt_trailer_append;
  localparam int LEN_W = 16;
  localparam int MAC_W = 48;
  localparam int IP_W  = 32;
  localparam logic [143:0] TRL = {8'h0A, "nihaoya,dongwazi~"};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             byte_vld = 1'b0;
  logic [7:0]       byte_in = '0;
  logic             pkt_end = 1'b0;
  logic [LEN_W-1:0] rx_len = '0;
  logic [MAC_W-1:0] dst_mac_i = '0;
  logic [IP_W-1:0]  dst_ip_i = '0;
  logic             fifo_we;
  logic [7:0]       fifo_wdata;
  logic [LEN_W-1:0] tx_len;
  logic             tx_go;
  logic [MAC_W-1:0] dst_mac_o;
  logic [IP_W-1:0]  dst_ip_o;

  int tests = 0;
  int fails = 0;

  pkt_trailer_append #(.LEN_W(LEN_W), .MAC_W(MAC_W), .IP_W(IP_W)) dut (.*);

  always #2 clk = ~clk;

  int         cyc = 0;
  int         wcnt = 0;
  int         last_wr = -1;
  int         go_cnt = 0;
  int         go_cyc = -1;
  logic [7:0] cap [0:63];

  always begin
    @(negedge clk);
    #1;
    cyc = cyc + 1;
    if (rst_n && fifo_we) begin
      if (wcnt < 64) cap[wcnt] = fifo_wdata;
      wcnt = wcnt + 1;
      last_wr = cyc;
    end
    if (rst_n && tx_go) begin
      go_cnt = go_cnt + 1;
      go_cyc = cyc;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int n, input int i);
    return 8'((n * 37 + i * 11 + 5) & 255);
  endfunction

  // mode 0: end strobe after last byte; 1: end with last byte; 2: noise in trailer
  task automatic run_pkt(input int n, input int mode, input logic [LEN_W-1:0] len);
    int mismatch = 0;
    @(negedge clk);
    wcnt = 0; go_cnt = 0; go_cyc = -1;
    for (int i = 0; i < n; i++) begin
      byte_vld = 1'b1;
      byte_in  = pat(n, i);
      if (mode == 1 && i == n - 1) begin
        pkt_end = 1'b1;
        rx_len  = len;
      end
      @(negedge clk);
    end
    byte_vld = 1'b0;
    if (mode != 1) begin
      pkt_end = 1'b1;
      rx_len  = len;
      @(negedge clk);
    end
    pkt_end = 1'b0;
    if (mode == 2) begin
      @(negedge clk);
      byte_vld = 1'b1; byte_in = 8'hFF;
      @(negedge clk);
      pkt_end = 1'b1; rx_len = 16'd999;
      @(negedge clk);
      pkt_end = 1'b0; byte_vld = 1'b1; byte_in = 8'hEE;
      @(negedge clk);
      byte_vld = 1'b0;
    end
    repeat (24) @(negedge clk);
    check("R2 write count", wcnt, n + 18);
    for (int i = 0; i < n && i < 64; i++)
      if (cap[i] != pat(n, i)) mismatch++;
    check("R1 payload bytes", mismatch, 0);
    mismatch = 0;
    for (int i = 0; i < 18; i++)
      if (n + i < 64 && cap[n + i] != TRL[143 - 8*i -: 8]) mismatch++;
    check("R2 trailer bytes", mismatch, 0);
    check("R3 tx_len", tx_len, 64'(LEN_W'(len + 18)));
    check("R4 go count", go_cnt, 1);
    check("R4 go timing", go_cyc, last_wr + 1);
    if (mode == 2) check("R5 ignored during trailer", wcnt + go_cnt, n + 19);
    if (mode == 1) check("R9 same-cycle end", wcnt, n + 18);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    dst_mac_i = 48'h0A1B2C3D4E5F;
    dst_ip_i  = 32'hC0A80107;
    repeat (3) @(negedge clk);
    #1;
    check("R8 reset we", fifo_we, 0);
    check("R8 reset go", tx_go, 0);
    check("R8 reset len", tx_len, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R6 idle no write", fifo_we, 0);
    check("R7 mac", dst_mac_o, 48'h0A1B2C3D4E5F);
    check("R7 ip", dst_ip_o, 32'hC0A80107);
    for (int n = 0; n <= 24; n++) run_pkt(n, 0, LEN_W'(n));
    check("R3 held after packet", tx_len, 24 + 18);
    for (int n = 1; n <= 6; n++) run_pkt(n, 1, LEN_W'(n));
    for (int n = 0; n <= 6; n++) run_pkt(n, 2, LEN_W'(n));
    run_pkt(5, 0, 16'd65530);
    check("R3 wrap", tx_len, 12);
    @(negedge clk);
    dst_mac_i = 48'hFFEEDDCCBBAA; dst_ip_i = 32'h01020304;
    #1;
    check("R7 mac change", dst_mac_o, 48'hFFEEDDCCBBAA);
    check("R7 ip change", dst_ip_o, 32'h01020304);
    check("R6 idle no write end", fifo_we, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule